// File: doc/BRIEF.md
# MDIO Management Transaction Controller

This block performs one management access at a time to an external Ethernet PHY over the two-wire MDC/MDIO link. A host loads a 16-bit data register (the value to send on a write) and then writes a command register that names the PHY, the register inside it, the direction and a clock-range code, with its busy bit set. The block then runs a complete clause-22 frame and clears busy when the frame ends. On a read, the data register holds the value returned by the PHY once busy clears.

MDC comes from the system clock through a divider. A 3-bit range code selects the divide ratio, and faster system clocks take larger ratios so that MDC stays within the PHY's limit. Each frame has a 32-bit preamble of ones, start `01`, an opcode (`01` write, `10` read), the PHY and register addresses MSB first, a two-bit turnaround and sixteen data bits MSB first. The block changes MDIO only on MDC falling edges. On reads it samples MDIO at MDC rising edges. MDIO is a split pin: `mdio_o` is the value, `mdio_oe` the output enable and `mdio_i` the pad input.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `cmd_rdata` and `data_rdata` read 0, `mdc` is low and `mdio_oe` is low.
- R2: Command register layout: PHY address in bits 15:11, register number in bits 10:6, bit 5 reads 0, range code in bits 4:2, write-select in bit 1 (1 = write, 0 = read), busy in bit 0. A command write made while idle stores the fields. If bit 0 of that write is 1, busy reads 1 from the next cycle on. If bit 0 is 0, the fields are stored and no frame starts.
- R3: Busy stays high for exactly 64·N system clock cycles, where N is the divide ratio. The frame has exactly 64 MDC rising edges, and MDC is low when busy clears.
- R4: Range codes 0, 1, 2, 3 and 4 give N = 16, 26, 42, 62 and 102. Codes 5 to 7 give 102. MDC stays high for N/2 cycles of each period and low for the other N/2.
- R5: A write frame drives, MSB first, 32 ones, `01`, `01`, the PHY address, the register number, `10` and the 16 data bits. `mdio_oe` is high for all 64 bits, and the data register keeps its value.
- R6: A read frame drives 32 ones, `01`, `10`, the PHY address and the register number. It releases `mdio_oe` from bit 46 (the first turnaround bit) through bit 63. It samples `mdio_i` at the MDC rising edges of bits 48 to 63 into a 16-bit value, MSB first, and this value is in the data register when busy clears.
- R7: Writes to the command or data register while busy is high have no effect.
- R8: While no frame is running, `mdc` is low and `mdio_oe` is low.
- R9: `mdio_o` does not change while `mdc` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 16 | Command register write value |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Data register write value |
| cmd_rdata | output | 16 | Command register contents with live busy bit |
| data_rdata | output | 16 | Data register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions assume that the host uses only the two write strobes and that the range code cannot change during a frame, which holds because the register is locked while busy. They also assume that `mdio_i` has a defined level whenever it is sampled. The stimulus stays within these limits. A PHY model in the bench returns a defined level on `mdio_i` at all times, and all writes are made half a cycle away from the clock edge. A new frame is launched only after busy has been seen low, except for the deliberate writes made during a frame to test R7.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int DW         = 16;
    localparam int PRE_LEN    = 32;
    localparam int HDR_LEN    = 4;
    localparam int TA_LEN     = 2;
    localparam int TA_POS     = PRE_LEN + HDR_LEN + PHY_AW + REG_AW;
    localparam int DATA_POS   = TA_POS + TA_LEN;
    localparam int FRAME_LEN  = DATA_POS + DW;
    localparam int BIT_CW     = $clog2(FRAME_LEN);
    localparam int RANGE_W    = 3;
    localparam int HALF_W     = 6;
    localparam int CMD_W      = 16;

    // command register bit positions
    localparam int CMD_BUSY_BIT  = 0;
    localparam int CMD_WR_BIT    = 1;
    localparam int CMD_RANGE_LSB = 2;
    localparam int CMD_REG_LSB   = 6;
    localparam int CMD_PHY_LSB   = 11;

    typedef struct packed {
        logic [PHY_AW-1:0]  phy;
        logic [REG_AW-1:0]  regn;
        logic [RANGE_W-1:0] range;
        logic               wr;
    } cmd_t;

    // half of the MDC period, in system clock cycles
    function automatic logic [HALF_W-1:0] half_period(input logic [RANGE_W-1:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            3'd0:    h = HALF_W'(8);
            3'd1:    h = HALF_W'(13);
            3'd2:    h = HALF_W'(21);
            3'd3:    h = HALF_W'(31);
            default: h = HALF_W'(51);
        endcase
        return h;
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              mdc_o,
    output logic              rise_o,
    output logic              fall_o
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              mdc;
    } gen_t;

    gen_t s_d, s_q;
    logic wrap;

    assign wrap = (s_q.cnt == half_i - HALF_W'(1));

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d = '0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc_o  = s_q.mdc;
    assign rise_o = en_i && wrap && !s_q.mdc;
    assign fall_o = en_i && wrap &&  s_q.mdc;

    // R4: the phase counter never passes the selected half period
    assert_half_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (s_q.cnt < half_i));

    // R8: MDC returns low once the enable drops
    assert_mdc_parks_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic [PHY_AW-1:0] phy_i,
    input  logic [REG_AW-1:0] reg_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdc_i,
    input  logic              mdio_i,
    output logic              active_o,
    output logic              done_o,
    output logic [DW-1:0]     rdata_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    localparam logic [BIT_CW-1:0] LAST_BIT  = BIT_CW'(FRAME_LEN - 1);
    localparam logic [BIT_CW-1:0] TA_BIT    = BIT_CW'(TA_POS);
    localparam logic [BIT_CW-1:0] DATA_BIT  = BIT_CW'(DATA_POS);

    typedef struct packed {
        logic                 active;
        logic                 wr;
        logic [BIT_CW-1:0]    bitcnt;
        logic [FRAME_LEN-1:0] shreg;
        logic [DW-1:0]        rcap;
    } eng_t;

    eng_t s_d, s_q;
    logic last_fall;

    assign last_fall = s_q.active && fall_i && (s_q.bitcnt == LAST_BIT);

    always_comb begin
        s_d = s_q;
        if (start_i && !s_q.active) begin
            s_d.active = 1'b1;
            s_d.wr     = wr_i;
            s_d.bitcnt = '0;
            s_d.rcap   = '0;
            s_d.shreg  = {{PRE_LEN{1'b1}}, 2'b01, (wr_i ? 2'b01 : 2'b10),
                          phy_i, reg_i, 2'b10, (wr_i ? wdata_i : {DW{1'b0}})};
        end else if (s_q.active) begin
            if (rise_i && !s_q.wr && (s_q.bitcnt >= DATA_BIT))
                s_d.rcap = {s_q.rcap[DW-2:0], mdio_i};
            if (fall_i) begin
                if (s_q.bitcnt == LAST_BIT) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.bitcnt = s_q.bitcnt + BIT_CW'(1);
                    s_d.shreg  = {s_q.shreg[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o  = s_q.active;
    assign done_o    = last_fall;
    assign rdata_o   = s_q.rcap;
    assign mdio_o    = s_q.active && s_q.shreg[FRAME_LEN-1];
    assign mdio_oe_o = s_q.active && (s_q.wr || (s_q.bitcnt < TA_BIT));

    // R9: the line value holds for as long as MDC is high
    assert_hold_while_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_i && $past(mdc_i)) |-> $stable(mdio_o));

    // R6: samples are taken only at the low-to-high MDC transition
    assert_sample_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |-> !mdc_i);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             data_wr,
    input  logic [DW-1:0]    data_wdata,
    output logic [CMD_W-1:0] cmd_rdata,
    output logic [DW-1:0]    data_rdata,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    typedef struct packed {
        cmd_t          cmd;
        logic [DW-1:0] data;
    } top_t;

    top_t s_d, s_q;

    logic          busy;
    logic          launch;
    logic          eng_done;
    logic [DW-1:0] eng_rdata;
    logic          tick_rise;
    logic          tick_fall;
    logic          unused_rsvd;

    assign unused_rsvd = cmd_wdata[5];
    assign launch = cmd_wr && !busy && cmd_wdata[CMD_BUSY_BIT];

    always_comb begin
        s_d = s_q;
        if (cmd_wr && !busy) begin
            s_d.cmd.phy   = cmd_wdata[CMD_PHY_LSB +: PHY_AW];
            s_d.cmd.regn  = cmd_wdata[CMD_REG_LSB +: REG_AW];
            s_d.cmd.range = cmd_wdata[CMD_RANGE_LSB +: RANGE_W];
            s_d.cmd.wr    = cmd_wdata[CMD_WR_BIT];
        end
        if (data_wr && !busy)
            s_d.data = data_wdata;
        if (eng_done && !s_q.cmd.wr)
            s_d.data = eng_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    mdio_mdc_gen u_mdc_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .half_i (half_period(s_q.cmd.range)),
        .mdc_o  (mdc),
        .rise_o (tick_rise),
        .fall_o (tick_fall)
    );

    mdio_frame_eng u_frame_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (launch),
        .wr_i      (cmd_wdata[CMD_WR_BIT]),
        .phy_i     (cmd_wdata[CMD_PHY_LSB +: PHY_AW]),
        .reg_i     (cmd_wdata[CMD_REG_LSB +: REG_AW]),
        .wdata_i   (s_q.data),
        .rise_i    (tick_rise),
        .fall_i    (tick_fall),
        .mdc_i     (mdc),
        .mdio_i    (mdio_i),
        .active_o  (busy),
        .done_o    (eng_done),
        .rdata_o   (eng_rdata),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

    assign cmd_rdata  = {s_q.cmd.phy, s_q.cmd.regn, 1'b0, s_q.cmd.range, s_q.cmd.wr, busy};
    assign data_rdata = s_q.data;

    // R2: a launch request seen while idle raises busy on the next cycle
    assert_launch_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[CMD_BUSY_BIT] && !busy) |=> busy);

    // R7: the command fields are frozen during a frame
    assert_cmd_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(s_q.cmd));

    // R7: the data register only moves at read completion during a frame
    assert_data_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done) |=> $stable(s_q.data));

    // R8: the management pins are quiet whenever no frame runs
    assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R3: busy clears with MDC already parked low
    assert_end_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !mdc);
endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [15:0] cmd_rdata;
    logic [15:0] data_rdata;
    logic        mdc;
    logic        mdio_i;
    logic        mdio_o;
    logic        mdio_oe;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    // PHY model state
    int          rcount = 0;
    logic [63:0] cap = '0;
    logic [63:0] oemask = '0;
    logic [15:0] rd_pat = '0;
    int          t0 = 0, t1 = 0, tf = 0;
    int          r9_err = 0;
    logic        prev_mdc = 1'b0;
    logic        prev_o = 1'b0;

    always #2.5 clk = ~clk;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY drives read data for bits 48..63, otherwise pulled up
    assign mdio_i = (rcount >= 48 && rcount <= 63) ? rd_pat[63 - rcount] : 1'b1;

    always @(posedge mdc) begin
        if (rcount < 64) begin
            cap[63 - rcount]    = mdio_o;
            oemask[63 - rcount] = mdio_oe;
        end
        if (rcount == 0) t0 = cyc;
        if (rcount == 1) t1 = cyc;
        rcount = rcount + 1;
    end

    always @(negedge mdc) begin
        if (rcount == 1) tf = cyc;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mdc && prev_mdc && (mdio_o !== prev_o)) r9_err = r9_err + 1;
        prev_mdc = mdc;
        prev_o   = mdio_o;
        if (cyc == 150000 && !finished) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input logic [2:0] code);
        case (code)
            3'd0: return 16;
            3'd1: return 26;
            3'd2: return 42;
            3'd3: return 62;
            default: return 102;
        endcase
    endfunction

    task automatic run_txn(input logic [2:0] rng, input logic wr, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] val, input bit poke);
        int n;
        int busy_cyc;
        logic [63:0] exp;
        logic [15:0] cmdw;
        n    = exp_ratio(rng);
        exp  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, val};
        cmdw = {phy, rg, 1'b0, rng, wr, 1'b1};
        rd_pat = val;
        @(negedge clk); data_wr = 1'b1; data_wdata = wr ? val : 16'h5A5A;
        @(negedge clk); data_wr = 1'b0;
        rcount = 0; cap = '0; oemask = '0;
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = cmdw;
        @(negedge clk); cmd_wr = 1'b0;
        chk("R2 busy raised and fields read back", 64'(cmd_rdata), 64'(cmdw));
        busy_cyc = 0;
        while (cmd_rdata[0] && busy_cyc < 20000) begin
            busy_cyc++;
            if (poke && busy_cyc == 100) begin
                cmd_wr = 1'b1; cmd_wdata = ~cmdw;
                data_wr = 1'b1; data_wdata = 16'h0F0F;
            end
            @(negedge clk);
            if (cmd_wr) begin
                cmd_wr = 1'b0; data_wr = 1'b0;
                chk("R7 command write ignored while busy", 64'(cmd_rdata), 64'(cmdw));
            end
        end
        chk("R3 busy length", 64'(busy_cyc), 64'(64 * n));
        chk("R3 MDC rising edges per frame", 64'(rcount), 64'd64);
        chk("R4 MDC period", 64'(t1 - t0), 64'(n));
        chk("R4 MDC high half", 64'(tf - t0), 64'(n / 2));
        chk("R8 idle pins after frame", {62'd0, mdc, mdio_oe}, 64'd0);
        if (wr) begin
            chk("R5 write frame bits", cap, exp);
            chk("R5 write frame output enable", oemask, {64{1'b1}});
            chk("R5 data register kept", 64'(data_rdata), 64'(val));
        end else begin
            chk("R6 read frame header", 64'(cap[63:18]), 64'(exp[63:18]));
            chk("R6 read output enable release", oemask, {{46{1'b1}}, 18'd0});
            chk("R6 read data captured", 64'(data_rdata), 64'(val));
        end
    endtask

    // {range, write, phy, reg, data or read pattern}
    localparam logic [29:0] VEC [6] = '{
        {3'd0, 1'b1, 5'h01, 5'h00, 16'hA5C3},
        {3'd1, 1'b0, 5'h1F, 5'h01, 16'h796D},
        {3'd2, 1'b1, 5'h10, 5'h1F, 16'h0001},
        {3'd3, 1'b0, 5'h0A, 5'h15, 16'h8001},
        {3'd4, 1'b1, 5'h15, 5'h0A, 16'h1234},
        {3'd7, 1'b0, 5'h00, 5'h02, 16'hC0DE}
    };

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 command register after reset", 64'(cmd_rdata), 64'd0);
        chk("R1 data register after reset", 64'(data_rdata), 64'd0);
        chk("R1 mdc low after reset", 64'(mdc), 64'd0);
        chk("R1 output enable low after reset", 64'(mdio_oe), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 6; i++)
            run_txn(VEC[i][29:27], VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], 1'b0);

        // R2: busy bit clear stores fields without launching
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = {5'h03, 5'h04, 1'b1, 3'd2, 1'b1, 1'b0};
        @(negedge clk); cmd_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk("R2 fields stored, no launch, bit5 reads 0", 64'(cmd_rdata),
            64'({5'h03, 5'h04, 1'b0, 3'd2, 1'b1, 1'b0}));
        chk("R8 mdc stays low without launch", 64'(mdc), 64'd0);

        // R7: writes during a read frame are dropped
        run_txn(3'd0, 1'b0, 5'h06, 5'h09, 16'h3C96, 1'b1);
        // R7: a data write during a write frame must not alter the frame
        run_txn(3'd0, 1'b1, 5'h11, 5'h0E, 16'hE718, 1'b1);

        chk("R9 mdio_o stable while mdc high", 64'(r9_err), 64'd0);
        summary();
    end
endmodule